// File: doc/BRIEF.md
# Single-Precision Significand Rounder

This block rounds a double-width significand to the 24 significant bits of a single-precision result. The significand is 53 bits wide and includes the hidden bit. The caller supplies the sign, a signed exponent, the significand, three extra low-order bits (G, R and X) left over from earlier alignment, and a 2-bit rounding mode. The block returns:

- the possibly bumped exponent,
- the rounded significand, with every bit below the kept 24 cleared,
- a flag that says the kept part was incremented,
- a flag that says discarded bits were nonzero.

The block makes no range, class or exception decisions. Overflow and underflow handling, and any exponent bias adjustment, belong to the surrounding conversion logic. The result is registered once, so it appears at the outputs one clock after the inputs are presented.

Top module: `sp_frac_rounder`

## Requirements
- R1: `inexact_o` is the OR of the guard bit (`frac_i[28]`), the round bit (`frac_i[27]`), every bit of `frac_i[26:0]`, and the inputs `g_i`, `r_i` and `x_i`. The last four of these (the low fraction bits and `g_i`, `r_i`, `x_i`) together form the sticky bit. `frac_i[52]` is the most significant (hidden) bit, and the kept part is `frac_i[52:29]` with its lsb at `frac_i[29]`.
- R2: With `mode_i` = 2'b00 (round to nearest), the kept part is incremented exactly when guard is 1 and at least one of lsb, round or sticky is 1.
- R3: With `mode_i` = 2'b01 (toward zero), the kept part is never incremented.
- R4: With `mode_i` = 2'b10 (toward +infinity), the block increments when sign is 0 and any of guard, round or sticky is 1. With 2'b11 (toward -infinity), it increments when sign is 1 and any of those bits is 1.
- R5: When the increment carries out of 24 bits, `frac_o[52:29]` becomes 1 followed by 23 zeros and `exp_o` equals `exp_i` + 1. Otherwise `exp_o` equals `exp_i`.
- R6: `frac_o[28:0]` is always zero.
- R7: `rounded_o` equals the increment decision. When it is 0, `frac_o[52:29]` equals `frac_i[52:29]`.
- R8: Outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | 13 | Signed exponent |
| frac_i | input | 53 | Significand, bit 52 is the hidden bit |
| g_i | input | 1 | Extra guard-type bit below the significand |
| r_i | input | 1 | Extra round-type bit below the significand |
| x_i | input | 1 | Extra sticky-type bit below the significand |
| mode_i | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| exp_o | output | 13 | Adjusted signed exponent |
| frac_o | output | 53 | Rounded significand, low 29 bits zero |
| rounded_o | output | 1 | Kept part was incremented |
| inexact_o | output | 1 | Discarded bits were nonzero |

## Verification
There is no state apart from the single result register, so any internal fault shows at the ports one clock after the offending inputs. A wrong tap position or sticky reduction shows up as a wrong `inexact_o` or a wrong increment in that same cycle. A mis-decoded mode shows as a `rounded_o` that disagrees with the sign and the discarded bits. A broken carry path shows only when the kept part is all ones, as a significand that is not a single leading one and an exponent that did not move.

// File: rtl/srnd_pkg.sv
package srnd_pkg;
    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_UP      = 2'b10,
        RM_DOWN    = 2'b11
    } rmode_e;

    typedef struct packed {
        logic lsb;
        logic guard;
        logic round;
        logic sticky;
    } rbits_t;
endpackage

// File: rtl/srnd_tap.sv
// Splits the wide significand into the kept part and the rounding bits.
module srnd_tap #(
    parameter int FRAC_W = 53,
    parameter int KEEP_W = 24
) (
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              g_i,
    input  logic              r_i,
    input  logic              x_i,
    output logic [KEEP_W-1:0] kept_o,
    output srnd_pkg::rbits_t  bits_o
);
    localparam int GPOS = FRAC_W - KEEP_W - 1;
    localparam int RPOS = GPOS - 1;

    logic low_any;

    generate
        if (RPOS > 0) begin : g_low
            assign low_any = |frac_i[RPOS-1:0];
        end else begin : g_nolow
            assign low_any = 1'b0;
        end
    endgenerate

    always_comb begin
        kept_o        = frac_i[FRAC_W-1 -: KEEP_W];
        bits_o.lsb    = frac_i[GPOS+1];
        bits_o.guard  = frac_i[GPOS];
        bits_o.round  = frac_i[RPOS];
        bits_o.sticky = low_any | g_i | r_i | x_i;
    end
endmodule

// File: rtl/srnd_decide.sv
// Increment decision per rounding mode.
module srnd_decide (
    input  srnd_pkg::rmode_e mode_i,
    input  logic             sign_i,
    input  srnd_pkg::rbits_t bits_i,
    output logic             inc_o,
    output logic             inexact_o
);
    logic any_lost;

    always_comb begin
        any_lost  = bits_i.guard | bits_i.round | bits_i.sticky;
        inexact_o = any_lost;
        unique case (mode_i)
            srnd_pkg::RM_NEAREST: inc_o = bits_i.guard &
                                          (bits_i.lsb | bits_i.round | bits_i.sticky);
            srnd_pkg::RM_ZERO:    inc_o = 1'b0;
            srnd_pkg::RM_UP:      inc_o = ~sign_i & any_lost;
            srnd_pkg::RM_DOWN:    inc_o = sign_i & any_lost;
            default:              inc_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/srnd_apply.sv
// Adds the increment and renormalises on carry-out.
module srnd_apply #(
    parameter int KEEP_W = 24,
    parameter int EXP_W  = 13
) (
    input  logic [KEEP_W-1:0]       kept_i,
    input  logic                    inc_i,
    input  logic signed [EXP_W-1:0] exp_i,
    output logic [KEEP_W-1:0]       kept_o,
    output logic signed [EXP_W-1:0] exp_o
);
    logic [KEEP_W:0] sum;

    always_comb begin
        sum = {1'b0, kept_i} + {{KEEP_W{1'b0}}, inc_i};
        if (sum[KEEP_W]) begin
            kept_o = {1'b1, sum[KEEP_W-1:1]};
            exp_o  = exp_i + EXP_W'(1);
        end else begin
            kept_o = sum[KEEP_W-1:0];
            exp_o  = exp_i;
        end
    end
endmodule

// File: rtl/sp_frac_rounder.sv
module sp_frac_rounder #(
    parameter int FRAC_W = 53,
    parameter int KEEP_W = 24,
    parameter int EXP_W  = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sign_i,
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [FRAC_W-1:0]       frac_i,
    input  logic                    g_i,
    input  logic                    r_i,
    input  logic                    x_i,
    input  logic [1:0]              mode_i,
    output logic signed [EXP_W-1:0] exp_o,
    output logic [FRAC_W-1:0]       frac_o,
    output logic                    rounded_o,
    output logic                    inexact_o
);
    localparam int DROP_W = FRAC_W - KEEP_W;

    typedef struct packed {
        logic signed [EXP_W-1:0] exp;
        logic [KEEP_W-1:0]       kept;
        logic                    rnd;
        logic                    inx;
    } res_t;

    logic [KEEP_W-1:0]       kept_raw;
    logic [KEEP_W-1:0]       kept_new;
    logic signed [EXP_W-1:0] exp_new;
    srnd_pkg::rbits_t        rbits;
    logic                    inc;
    logic                    inx;
    res_t                    res_d;
    res_t                    res_q;

    srnd_tap #(.FRAC_W(FRAC_W), .KEEP_W(KEEP_W)) u_tap (
        .frac_i (frac_i),
        .g_i    (g_i),
        .r_i    (r_i),
        .x_i    (x_i),
        .kept_o (kept_raw),
        .bits_o (rbits)
    );

    srnd_decide u_decide (
        .mode_i    (srnd_pkg::rmode_e'(mode_i)),
        .sign_i    (sign_i),
        .bits_i    (rbits),
        .inc_o     (inc),
        .inexact_o (inx)
    );

    srnd_apply #(.KEEP_W(KEEP_W), .EXP_W(EXP_W)) u_apply (
        .kept_i (kept_raw),
        .inc_i  (inc),
        .exp_i  (exp_i),
        .kept_o (kept_new),
        .exp_o  (exp_new)
    );

    always_comb begin
        res_d      = '0;
        res_d.exp  = exp_new;
        res_d.kept = kept_new;
        res_d.rnd  = inc;
        res_d.inx  = inx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign exp_o     = res_q.exp;
    assign frac_o    = {res_q.kept, {DROP_W{1'b0}}};
    assign rounded_o = res_q.rnd;
    assign inexact_o = res_q.inx;
endmodule

// File: rtl/srnd_chk.sv
module srnd_chk #(
    parameter int FRAC_W = 53,
    parameter int KEEP_W = 24,
    parameter int EXP_W  = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sign_i,
    input logic signed [EXP_W-1:0] exp_i,
    input logic [FRAC_W-1:0]       frac_i,
    input logic                    g_i,
    input logic                    r_i,
    input logic                    x_i,
    input logic [1:0]              mode_i,
    input logic signed [EXP_W-1:0] exp_o,
    input logic [FRAC_W-1:0]       frac_o,
    input logic                    rounded_o,
    input logic                    inexact_o
);
    localparam int DROP_W = FRAC_W - KEEP_W;
    localparam int GPOS   = DROP_W - 1;

    assert_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_i[GPOS:0] == '0 && !g_i && !r_i && !x_i) |=> !inexact_o);

    assert_nearest_noguard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && !frac_i[GPOS]) |=> !rounded_o);

    assert_zero_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |=> !rounded_o);

    assert_up_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && sign_i) |=> !rounded_o);

    assert_down_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11 && !sign_i) |=> !rounded_o);

    assert_exp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (exp_o == $past(exp_i) || exp_o == $past(exp_i) + EXP_W'(1)));

    assert_low_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frac_o[DROP_W-1:0] == '0);

    assert_round_inexact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rounded_o |-> inexact_o);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rounded_o ||
                  (frac_o[FRAC_W-1:DROP_W] == $past(frac_i[FRAC_W-1:DROP_W]) &&
                   exp_o == $past(exp_i))));
endmodule

bind sp_frac_rounder srnd_chk #(.FRAC_W(FRAC_W), .KEEP_W(KEEP_W), .EXP_W(EXP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .exp_i(exp_i), .frac_i(frac_i),
    .g_i(g_i), .r_i(r_i), .x_i(x_i), .mode_i(mode_i), .exp_o(exp_o),
    .frac_o(frac_o), .rounded_o(rounded_o), .inexact_o(inexact_o)
);

// File: tb/sp_frac_rounder_test.sv
module sp_frac_rounder_test;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 2000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sign_i = 1'b0;
    logic signed [12:0] exp_i = '0;
    logic [52:0]        frac_i = '0;
    logic               g_i = 1'b0, r_i = 1'b0, x_i = 1'b0;
    logic [1:0]         mode_i = 2'b00;
    logic signed [12:0] exp_o;
    logic [52:0]        frac_o;
    logic               rounded_o, inexact_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_frac_rounder uut (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .exp_i(exp_i), .frac_i(frac_i),
        .g_i(g_i), .r_i(r_i), .x_i(x_i), .mode_i(mode_i), .exp_o(exp_o),
        .frac_o(frac_o), .rounded_o(rounded_o), .inexact_o(inexact_o)
    );

    task automatic ref_calc(input logic s, input logic signed [12:0] e, input logic [52:0] f,
                            input logic g, input logic r, input logic x, input logic [1:0] m,
                            output logic signed [12:0] eo, output logic [52:0] fo,
                            output logic rnd, output logic inx);
        logic lsb, gd, rd, st, inc;
        logic [24:0] sum;
        lsb = f[29]; gd = f[28]; rd = f[27];
        st  = (|f[26:0]) | g | r | x;
        inx = gd | rd | st;
        case (m)
            2'b00: inc = gd & (lsb | rd | st);
            2'b01: inc = 1'b0;
            2'b10: inc = !s & inx;
            default: inc = s & inx;
        endcase
        rnd = inc;
        sum = {1'b0, f[52:29]} + {24'd0, inc};
        if (sum[24]) begin
            fo = {1'b1, 52'd0};
            eo = e + 13'sd1;
        end else begin
            fo = {sum[23:0], 29'd0};
            eo = e;
        end
    endtask

    task automatic apply_and_check(input string tag);
        logic signed [12:0] ee;
        logic [52:0] ef;
        logic er, ei;
        ref_calc(sign_i, exp_i, frac_i, g_i, r_i, x_i, mode_i, ee, ef, er, ei);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (exp_o !== ee || frac_o !== ef || rounded_o !== er) begin
            failures++;
            $display("FAIL %s: exp=%0d frac=%h rnd=%b expected exp=%0d frac=%h rnd=%b",
                     tag, exp_o, frac_o, rounded_o, ee, ef, er);
        end
        checks++;
        if (inexact_o !== ei) begin
            failures++;
            $display("FAIL R1: inexact=%b expected %b", inexact_o, ei);
        end
        checks++;
        if (frac_o[28:0] !== 29'd0) begin
            failures++;
            $display("FAIL R6: low=%h expected 0", frac_o[28:0]);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00: return "R2";
            2'b01: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        int src;
        unused_seed = $urandom(32'h5eed_0123);
        src = 0;
        // R8: reset holds outputs at zero even with busy inputs
        frac_i = '1; g_i = 1; exp_i = 13'sd50; mode_i = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (exp_o !== '0 || frac_o !== '0 || rounded_o !== 1'b0 || inexact_o !== 1'b0) begin
            failures++;
            $display("FAIL R8: exp=%0d frac=%h rnd=%b inx=%b expected all zero",
                     exp_o, frac_o, rounded_o, inexact_o);
        end
        rst_n = 1'b1;

        // R8: result appears one edge later
        sign_i = 0; exp_i = 13'sd7; frac_i = {1'b1, 52'd0}; g_i = 0; r_i = 0; x_i = 0; mode_i = 2'b00;
        apply_and_check("R8");

        // exhaustive lsb/guard/round/sticky per mode and sign
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++)
                for (int l = 0; l < 2; l++)
                    for (int gd = 0; gd < 2; gd++)
                        for (int rd = 0; rd < 2; rd++)
                            for (int st = 0; st < 2; st++) begin
                                frac_i = {1'b1, 20'($urandom()), 32'($urandom())};
                                frac_i[29] = l[0]; frac_i[28] = gd[0]; frac_i[27] = rd[0];
                                frac_i[26:0] = '0;
                                g_i = 0; r_i = 0; x_i = 0;
                                if (st != 0) begin
                                    case (src % 4)
                                        0: frac_i[$urandom() % 27] = 1'b1;
                                        1: g_i = 1'b1;
                                        2: r_i = 1'b1;
                                        default: x_i = 1'b1;
                                    endcase
                                    src++;
                                end
                                sign_i = s[0]; mode_i = m[1:0];
                                exp_i = 13'($signed(($urandom() % 400) - 200));
                                apply_and_check(mode_tag(mode_i));
                            end

        // R5: all-ones kept part carries out in each incrementing case
        for (int m = 0; m < 4; m++) begin
            frac_i = '1; g_i = 0; r_i = 0; x_i = 0;
            mode_i = m[1:0]; sign_i = (m == 3);
            exp_i = 13'sd127;
            apply_and_check("R5");
        end
        frac_i = {24'hFFFFFF, 1'b1, 28'd0}; mode_i = 2'b00; sign_i = 0; exp_i = -13'sd3;
        apply_and_check("R5");

        // R7: exact input never changes the value
        frac_i = {24'hABCDEF, 29'd0}; mode_i = 2'b10; sign_i = 0; exp_i = 13'sd1;
        apply_and_check("R7");

        // constrained random
        for (int i = 0; i < NRAND; i++) begin
            frac_i = {1'b1, 20'($urandom()), 32'($urandom())};
            if ($urandom() % 4 == 0) frac_i[26:0] = '0;
            if ($urandom() % 8 == 0) frac_i[52:29] = '1;
            g_i = ($urandom() % 6 == 0); r_i = ($urandom() % 6 == 0); x_i = ($urandom() % 6 == 0);
            sign_i = $urandom() % 2; mode_i = 2'($urandom());
            exp_i = 13'($signed(($urandom() % 2000) - 1000));
            apply_and_check("R7");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule